// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a synthesizable behavioural model of a single byte-wide flash device that can be erased by sector. The host reaches it over a clocked bus. In any cycle where the chip select and write strobe are both high, the block takes in one write. In any cycle where the chip select and read strobe are both high, it registers one read. Writes go to a small command sequencer. The sequencer looks for keyed address/data unlock cycles and from them starts an embedded program, a sector erase or a chip erase. Each of these operations runs for a fixed number of clock cycles, and the `busy` output stays high for that whole time.

While an operation is running, reads from the affected region return a status byte in place of array data. Bit 7 of that byte carries a polling value, and bit 6 flips on every status read. During a sector erase, reads from any other sector still return stored data.

The array is scaled down so it can be simulated. It keeps 2^OFF_W bytes per sector. The sector is taken from the top SECT_W address bits and the offset from the low OFF_W bits, so the address bits in between alias. The array has no reset, since flash contents are non-volatile.

Top module: `flash_cmd_dev`

## Requirements
- R1: While `rst_n` is low and straight after it rises, `busy` is 0, `bus_rdata` is 00h and the sequencer is in read-array mode, so the next valid command sequence is accepted.
- R2: Programming takes four writes: AAh to key address 5555h, then 55h to 2AAAh, then A0h to 5555h, then the data to the target address. Key addresses are compared on `bus_addr[15:0]` only. The stored byte becomes the old byte AND the new data, at index {addr[20:16], addr[OFF_W-1:0]}.
- R3: `busy` rises at the clock edge that accepts the final command write. It stays high for exactly PROG_CYC cycles after a program and ERASE_CYC cycles after an erase, and it never rises without an accepted write.
- R4: During a program, every read returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, and bits 5..0 are 0.
- R5: Bit 6 of the status byte flips on each successive status read. Once `busy` falls, reads return array data, so the bit stops flipping.
- R6: A sector erase is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. Every byte of sector addr[20:16] becomes FFh and all other sectors are left unchanged.
- R7: The same five-write prefix followed by 10h@5555h sets every byte of the array to FFh.
- R8: During either erase, bit 7 of a status read is 0.
- R9: During a sector erase, a read from a different sector returns that sector's stored byte.
- R10: A write that does not match the next expected unlock or command step throws away the partial sequence and returns to read-array mode. A data write that follows it programs nothing.
- R11: Writes accepted while `busy` is high are ignored, including complete command sequences.
- R12: Pulling `rst_n` low during an operation clears `busy` at once and leaves the target byte unchanged. The block then accepts new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer, timer and read path |
| bus_sel | input | 1 | Chip select, active high |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_rd | input | 1 | Read strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The array is first cleared with a chip erase. A near-exhaustive sweep then programs every sector twice with arithmetically derived bytes and reads all 256 locations back. This separates a correct AND-merge from overwrite, and correct index decoding from aliasing; half of the unlocks use key addresses with the high bits set, to confirm that only the low 16 bits are keyed. Status reads are taken during a program with data bit 7 at 0 and at 1, and during both kinds of erase. These reads tell the polling bit apart from array data and show the toggle bit stopping once the operation ends. Broken sequences, writes issued while busy, and a reset in the middle of an operation are each followed by readback of the byte they could have changed.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PDATA, SQ_EKEY0, SQ_EKEY1, SQ_EKEY2
  } seq_t;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_t;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;

  function automatic logic key_hit(input logic [15:0] a, input logic [7:0] d,
                                   input logic [15:0] ka, input logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] key_addr,
  input  logic [7:0]  wdata,
  output logic        go_prog,
  output logic        go_sect,
  output logic        go_chip,
  output seq_t        state_o
);

  seq_t state, state_nx;

  always_comb begin
    state_nx = state;
    go_prog  = 1'b0;
    go_sect  = 1'b0;
    go_chip  = 1'b0;
    if (wr_en) begin
      state_nx = SQ_IDLE;
      unique case (state)
        SQ_IDLE:  if (key_hit(key_addr, wdata, KEY_ADDR_A, CODE_UNLK1)) state_nx = SQ_KEY1;
        SQ_KEY1:  if (key_hit(key_addr, wdata, KEY_ADDR_B, CODE_UNLK2)) state_nx = SQ_KEY2;
        SQ_KEY2: begin
          if (key_hit(key_addr, wdata, KEY_ADDR_A, CODE_PROG))       state_nx = SQ_PDATA;
          else if (key_hit(key_addr, wdata, KEY_ADDR_A, CODE_ERASE)) state_nx = SQ_EKEY0;
        end
        SQ_PDATA: go_prog = 1'b1;
        SQ_EKEY0: if (key_hit(key_addr, wdata, KEY_ADDR_A, CODE_UNLK1)) state_nx = SQ_EKEY1;
        SQ_EKEY1: if (key_hit(key_addr, wdata, KEY_ADDR_B, CODE_UNLK2)) state_nx = SQ_EKEY2;
        SQ_EKEY2: begin
          if (key_hit(key_addr, wdata, KEY_ADDR_A, CODE_CHIP)) go_chip = 1'b1;
          else if (wdata == CODE_SECT)                         go_sect = 1'b1;
        end
        default: state_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nx;
  end

  assign state_o = state;

  // Each launched operation leaves the sequencer back in read-array mode.
  assert_launch_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_sect || go_chip) |=> state == SQ_IDLE);

endmodule

// File: rtl/fcmd_timer.sv
module fcmd_timer
  import fcmd_pkg::*;
#(
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 256,
  parameter int IDX_W     = 8,
  parameter int SECT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_sect,
  input  logic              go_chip,
  input  logic [IDX_W-1:0]  go_idx,
  input  logic [SECT_W-1:0] go_sect_no,
  input  logic [7:0]        go_data,
  output logic              busy,
  output op_t               op,
  output logic              done_prog,
  output logic              done_sect,
  output logic              done_chip,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [7:0]        tgt_data,
  output logic [SECT_W-1:0] esec
);

  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             go_any;
  logic             last;

  assign go_any = go_prog | go_sect | go_chip;
  assign last   = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op       <= OP_NONE;
      cnt      <= '0;
      tgt_idx  <= '0;
      tgt_data <= '0;
      esec     <= '0;
    end else if (!busy && go_any) begin
      busy     <= 1'b1;
      op       <= go_prog ? OP_PROG : (go_chip ? OP_CHIP : OP_SECT);
      cnt      <= go_prog ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
      tgt_idx  <= go_idx;
      tgt_data <= go_data;
      esec     <= go_sect_no;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        op   <= OP_NONE;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign done_prog = last && (op == OP_PROG);
  assign done_sect = last && (op == OP_SECT);
  assign done_chip = last && (op == OP_CHIP);

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);

  assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |-> !busy);

  assert_one_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_prog, go_sect, go_chip}));

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
  parameter int IDX_W  = 8,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              pgm,
  input  logic [IDX_W-1:0]  pgm_idx,
  input  logic [7:0]        pgm_data,
  input  logic              wipe_sect,
  input  logic [SECT_W-1:0] sect_no,
  input  logic              wipe_all,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_byte
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int OFF_W = IDX_W - SECT_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wipe_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wipe_sect) begin
      for (int i = 0; i < DEPTH; i++)
        if (i[IDX_W-1:OFF_W] == sect_no) mem[i] <= 8'hFF;
    end else if (pgm) begin
      mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
    end
  end

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/flash_cmd_dev.sv
module flash_cmd_dev
  import fcmd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int SECT_W    = 5,
  parameter int OFF_W     = 3,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              busy
);

  localparam int IDX_W = SECT_W + OFF_W;

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return {sect_of(a), a[OFF_W-1:0]};
  endfunction

  logic              wr_fire, rd_fire;
  logic              go_prog, go_sect, go_chip;
  logic              done_prog, done_sect, done_chip;
  op_t               op;
  seq_t              seq_state;
  logic [IDX_W-1:0]  tgt_idx;
  logic [7:0]        tgt_data;
  logic [SECT_W-1:0] esec;
  logic [7:0]        arr_rd;
  logic              status_sel;
  logic              tog;
  logic [7:0]        status_byte;

  assign wr_fire = bus_sel & bus_wr & ~busy;
  assign rd_fire = bus_sel & bus_rd;

  fcmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .key_addr (bus_addr[15:0]),
    .wdata    (bus_wdata),
    .go_prog  (go_prog),
    .go_sect  (go_sect),
    .go_chip  (go_chip),
    .state_o  (seq_state)
  );

  fcmd_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .IDX_W     (IDX_W),
    .SECT_W    (SECT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_prog    (go_prog),
    .go_sect    (go_sect),
    .go_chip    (go_chip),
    .go_idx     (idx_of(bus_addr)),
    .go_sect_no (sect_of(bus_addr)),
    .go_data    (bus_wdata),
    .busy       (busy),
    .op         (op),
    .done_prog  (done_prog),
    .done_sect  (done_sect),
    .done_chip  (done_chip),
    .tgt_idx    (tgt_idx),
    .tgt_data   (tgt_data),
    .esec       (esec)
  );

  fcmd_array #(
    .IDX_W  (IDX_W),
    .SECT_W (SECT_W)
  ) u_array (
    .clk       (clk),
    .pgm       (done_prog),
    .pgm_idx   (tgt_idx),
    .pgm_data  (tgt_data),
    .wipe_sect (done_sect),
    .sect_no   (esec),
    .wipe_all  (done_chip),
    .rd_idx    (idx_of(bus_addr)),
    .rd_byte   (arr_rd)
  );

  // Status replaces array data unless the read targets a sector outside a running sector erase.
  assign status_sel  = busy && ((op != OP_SECT) || (sect_of(bus_addr) == esec));
  assign status_byte = {(op == OP_PROG) ? ~tgt_data[7] : 1'b0, tog, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      tog       <= 1'b0;
    end else if (rd_fire) begin
      bus_rdata <= status_sel ? status_byte : arr_rd;
      if (status_sel) tog <= ~tog;
    end
  end

  assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_fire));

  assert_erase_poll_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && status_sel && op != OP_PROG) |=> !bus_rdata[7]);

  assert_other_sector_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && busy && op == OP_SECT && sect_of(bus_addr) != esec)
      |=> bus_rdata == $past(arr_rd));

  assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && status_sel) ##1 (rd_fire && status_sel) |=> bus_rdata[6] != $past(bus_rdata[6]));

  assert_seq_idle_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_state != SQ_IDLE) |=> seq_state == $past(seq_state));

endmodule

// File: tb/flash_cmd_dev_bench.sv
module flash_cmd_dev_bench;

  localparam int PC = 20;
  localparam int EC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        busy;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  flash_cmd_dev #(.PROG_CYC(PC), .ERASE_CYC(EC)) u_flash_cmd_dev (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  function automatic logic [20:0] mk(input int s, input int o);
    return {s[4:0], 13'h0, o[2:0]};
  endfunction

  function automatic logic [7:0] mi(input int s, input int o);
    return {s[4:0], o[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic prog_seq(input logic [20:0] a, input logic [7:0] d, input logic [4:0] hi);
    wr({hi, 16'h5555}, 8'hAA);
    wr({hi, 16'h2AAA}, 8'h55);
    wr({hi, 16'h5555}, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_seq(input logic [20:0] a, input logic [7:0] d);
    wr(21'h05555, 8'hAA);
    wr(21'h02AAA, 8'h55);
    wr(21'h05555, 8'h80);
    wr(21'h05555, 8'hAA);
    wr(21'h02AAA, 8'h55);
    wr(a, d);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int s = 0; s < 32; s++)
      for (int o = 0; o < 8; o++) begin
        rd(mk(s, o), v);
        chk(v == model[mi(s, o)], req, v, model[mi(s, o)]);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v1, v2, v3, e;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", {7'b0, busy}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", {7'b0, busy}, 8'h00);
    chk(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 8'h00);

    // R7 chip erase, R8 poll bit during erase
    erase_seq(21'h05555, 8'h10);
    chk(busy == 1'b1, "R1 R7 command accepted after reset", {7'b0, busy}, 8'h01);
    rd(mk(4, 4), v1);
    rd(mk(20, 1), v2);
    chk(v1[7] == 1'b0, "R8 chip erase poll bit", v1, 8'h00);
    chk(v1[6] != v2[6], "R5 toggle during chip erase", v2, {~v1[6], 6'b0} << 0);
    wait_idle();
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    sweep("R7 chip erase fills FFh");

    // R3 exact program duration
    prog_seq(mk(2, 1), 8'h5A, 5'd0);
    chk(busy == 1'b1, "R3 busy at final write", {7'b0, busy}, 8'h01);
    repeat (PC - 1) @(negedge clk);
    chk(busy == 1'b1, "R3 busy last cycle", {7'b0, busy}, 8'h01);
    @(negedge clk);
    chk(busy == 1'b0, "R3 busy falls after PROG_CYC", {7'b0, busy}, 8'h00);
    model[mi(2, 1)] = model[mi(2, 1)] & 8'h5A;

    // R4 status during program with data bit7 = 0, R5 toggle
    prog_seq(mk(3, 2), 8'h3C, 5'd0);
    rd(mk(3, 2), v1);
    rd(mk(30, 0), v2);
    rd(mk(3, 2), v3);
    chk(v1[7] == 1'b1, "R4 poll bit is ~D7 (D7=0)", v1, 8'h80);
    chk(v1[5:0] == 6'b0, "R4 low status bits zero", v1, {v1[7:6], 6'b0});
    chk(v1[6] != v2[6], "R5 toggle flips read 1-2", v2, {v2[7], ~v1[6], 6'b0});
    chk(v2[6] != v3[6], "R5 toggle flips read 2-3", v3, {v3[7], ~v2[6], 6'b0});
    wait_idle();
    model[mi(3, 2)] = model[mi(3, 2)] & 8'h3C;
    rd(mk(3, 2), v1);
    rd(mk(3, 2), v2);
    chk(v1 == model[mi(3, 2)], "R5 array data after completion", v1, model[mi(3, 2)]);
    chk(v2 == v1, "R5 toggling stopped", v2, v1);

    // R4 with data bit7 = 1
    prog_seq(mk(3, 3), 8'hC3, 5'd0);
    rd(mk(3, 3), v1);
    chk(v1[7] == 1'b0, "R4 poll bit is ~D7 (D7=1)", v1, {1'b0, v1[6], 6'b0});
    wait_idle();
    model[mi(3, 3)] = model[mi(3, 3)] & 8'hC3;

    // R2 sweep: two programs per sector, alias keys on odd sectors
    for (int s = 0; s < 32; s++) begin
      int o = s % 8;
      logic [7:0] d1, d2;
      d1 = 8'((s * 37 + 11) & 255);
      d2 = 8'((s * 91 + 5) & 255);
      prog_seq(mk(s, o), d1, (s % 2 == 1) ? s[4:0] : 5'd0);
      wait_idle();
      prog_seq(mk(s, o), d2, (s % 2 == 1) ? 5'(31 - s) : 5'd0);
      wait_idle();
      model[mi(s, o)] = model[mi(s, o)] & d1 & d2;
    end
    sweep("R2 program AND-merge sweep");

    // R6 sector erase of sector 5, R8, R9
    erase_seq(mk(5, 7), 8'h30);
    rd(mk(9, 1), v1);
    chk(v1 == model[mi(9, 1)], "R9 other sector reads data", v1, model[mi(9, 1)]);
    rd(mk(5, 0), v2);
    chk(v2[7] == 1'b0 && v2[5:0] == 6'b0, "R8 sector erase poll bit", v2, {1'b0, v2[6], 6'b0});
    wait_idle();
    for (int o = 0; o < 8; o++) model[mi(5, o)] = 8'hFF;
    sweep("R6 sector erase only sector 5");

    // R10 broken sequences
    e = model[mi(9, 4)];
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h12); wr(mk(9, 4), 8'h00);
    @(negedge clk);
    chk(busy == 1'b0, "R10 bad command code", {7'b0, busy}, 8'h00);
    rd(mk(9, 4), v);
    chk(v == e, "R10 bad command code no program", v, e);
    wr(21'h05555, 8'hAA); wr(21'h02AAB, 8'h55); wr(21'h05555, 8'hA0); wr(mk(9, 4), 8'h00);
    @(negedge clk);
    chk(busy == 1'b0, "R10 bad key address", {7'b0, busy}, 8'h00);
    rd(mk(9, 4), v);
    chk(v == e, "R10 bad key address no program", v, e);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h80);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(mk(9, 4), 8'h20);
    @(negedge clk);
    chk(busy == 1'b0, "R10 bad erase code", {7'b0, busy}, 8'h00);
    sweep("R10 nothing changed");

    // R11 writes during busy ignored
    prog_seq(mk(10, 0), 8'h0F, 5'd0);
    prog_seq(mk(11, 0), 8'h00, 5'd0);
    wait_idle();
    chk(busy == 1'b0, "R11 no second operation", {7'b0, busy}, 8'h00);
    model[mi(10, 0)] = model[mi(10, 0)] & 8'h0F;
    rd(mk(11, 0), v);
    chk(v == model[mi(11, 0)], "R11 ignored target unchanged", v, model[mi(11, 0)]);
    rd(mk(10, 0), v);
    chk(v == model[mi(10, 0)], "R11 first program done", v, model[mi(10, 0)]);

    // R12 reset aborts
    prog_seq(mk(12, 5), 8'h00, 5'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R12 busy cleared by reset", {7'b0, busy}, 8'h00);
    rst_n = 1'b1;
    rd(mk(12, 5), v);
    chk(v == model[mi(12, 5)], "R12 aborted byte unchanged", v, model[mi(12, 5)]);
    prog_seq(mk(12, 5), 8'h81, 5'd0);
    wait_idle();
    model[mi(12, 5)] = model[mi(12, 5)] & 8'h81;
    rd(mk(12, 5), v);
    chk(v == model[mi(12, 5)], "R12 commands work after reset", v, model[mi(12, 5)]);
    sweep("R2 R12 final sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule